// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Row Refresh

This block sits between a simple host request port and a 64K-location, 4-bit-wide dynamic RAM that has eight address pins. The host asks for an access by raising `req_valid` with a 16-bit address, a write flag and write data. The sequencer takes the request only while `req_ready` is high. It registers the request and plays it out on the memory pins in two halves. The low byte goes out first and is strobed by the falling row strobe. The high byte follows on the same pins and is strobed by the falling column strobe. Read data is captured as the column phase ends, and every access, read or write, is answered with a one-cycle `rsp_done` pulse.

Stored charge decays, so a free-running timer raises a refresh request once per retention interval divided by the number of rows. An 8-bit row counter supplies the row to refresh. Each refresh is a row-strobe-only cycle with the column strobe held high, and the counter steps after every one, wrapping from 255 to 0. A pending refresh is served before a waiting host request.

The controller is a state machine with six states. IDLE goes to RFSH when a refresh is pending and goes to ROW when a request is accepted. ROW goes to COL after T_ROW cycles. COL goes to HOLD after T_COL cycles. HOLD goes to PRE after T_HOLD cycles. RFSH goes to PRE after T_RFSH cycles. PRE goes back to IDLE after T_PRE cycles. Apart from these, each state stays put while its cycle counter runs down.

Top module: `dram_mux_ctrl`

## Requirements
- R1: `req_ready` is high only in IDLE with no refresh pending. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after it is taken.
- R2: After a request is taken, the row strobe falls with the address pins carrying address bits 7:0. The row strobe stays low through the row phase, which lasts T_ROW cycles.
- R3: In the column phase, the column strobe is low for T_COL cycles and the address pins carry address bits 15:8. The column strobe is never low while the row strobe is high.
- R4: In a write, the write enable is low and the output enable is high while the column strobe is low, and the data pins are driven with the registered write data.
- R5: In a read, the output enable is low and the write enable is high while the column strobe is low. The data pins are not driven, and the value on `dram_dq_in` in the last column cycle is returned on `rsp_rdata`.
- R6: The write enable and output enable are never low together.
- R7: `rsp_done` is high for exactly one cycle per access. It goes high in the cycle right after the column phase ends, and responses come back in request order.
- R8: Between two row-strobe-low periods, the row strobe stays high for at least T_PRE cycles.
- R9: A refresh is requested every RETAIN_CYCLES/2^ROW_BITS cycles. Each refresh starts no later than that interval plus one access length after the previous one.
- R10: A refresh cycle drives the refresh row on the address pins and pulses the row strobe while the column strobe stays high.
- R11: The refresh row starts at 0 after reset, steps by one per refresh, and wraps from 255 to 0.
- R12: When a refresh is pending in IDLE, it starts before a waiting host request.
- R13: During and just after reset, all four strobes are high, `rsp_done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Location; bits 7:0 are the row, bits 15:8 the column |
| req_wdata | input | 4 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read data, valid with `rsp_done` after a read |
| dram_addr | output | 8 | Multiplexed address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and chip select, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
If the state register or the phase counter is wrong, the fault reaches the pins in the same access. Examples are a phase that is cut short, an address half on the wrong strobe, or a column strobe outside a row cycle. A response that comes early, late or twice shows at the next `rsp_done`. A fault in the refresh timer or row counter does not show until the next refresh. A skipped row or an overdue refresh is seen no later than one refresh interval after it happens, and a wrong wrap is seen at the 257th refresh.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_HOLD,
        ST_PRE,
        ST_RFSH
    } seq_state_t;

    typedef enum logic [1:0] {
        ASEL_ROW,
        ASEL_COL,
        ASEL_REF
    } addr_sel_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int RETAIN_CYCLES = 800000,
    parameter int ROW_BITS      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant,
    input  logic                finish,
    output logic                pend,
    output logic [ROW_BITS-1:0] row
);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int INTERVAL = RETAIN_CYCLES / ROWS;
    localparam int TW       = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = (tmr == TW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr  <= '0;
            pend <= 1'b0;
            row  <= '0;
        end else begin
            tmr <= tick ? '0 : tmr + 1'b1;
            if (tick)
                pend <= 1'b1;
            else if (grant)
                pend <= 1'b0;
            if (finish)
                row <= row + 1'b1;
        end
    end

    // R9: a new tick must never land on a request still waiting
    p_tick_not_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && pend && !grant));

    // R11: counter wraps to row 0 after the last row
    p_row_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && row == {ROW_BITS{1'b1}}) |=> (row == '0));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS = 8
) (
    input  addr_sel_t             sel,
    input  logic [2*ROW_BITS-1:0] host_addr,
    input  logic [ROW_BITS-1:0]   ref_row,
    output logic [ROW_BITS-1:0]   pin_addr
);
    always_comb begin
        unique case (sel)
            ASEL_COL: pin_addr = host_addr[2*ROW_BITS-1:ROW_BITS];
            ASEL_REF: pin_addr = ref_row;
            default:  pin_addr = host_addr[ROW_BITS-1:0];
        endcase
    end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS = 8,
    parameter int DATA_W   = 4,
    parameter int T_ROW    = 2,
    parameter int T_COL    = 2,
    parameter int T_HOLD   = 1,
    parameter int T_PRE    = 2,
    parameter int T_RFSH   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [2*ROW_BITS-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    input  logic                  ref_pend,
    output logic                  ref_grant,
    output logic                  ref_finish,
    output addr_sel_t             addr_sel,
    output logic [2*ROW_BITS-1:0] host_addr,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic                  oe_n,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    input  logic [DATA_W-1:0]     dq_in
);
    localparam int TMAX = max2(max2(max2(T_ROW, T_COL), max2(T_HOLD, T_PRE)), T_RFSH);
    localparam int CW   = $clog2(TMAX + 1);

    seq_state_t        state, nxt;
    logic [CW-1:0]     cnt;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;
    logic              cnt_zero;
    logic              col_end;

    assign req_ready  = (state == ST_IDLE) && !ref_pend;
    assign accept     = req_valid && req_ready;
    assign ref_grant  = (state == ST_IDLE) && ref_pend;
    assign cnt_zero   = (cnt == '0);
    assign ref_finish = (state == ST_RFSH) && cnt_zero;
    assign col_end    = (state == ST_COL) && cnt_zero;
    assign dq_out     = wdata_q;

    function automatic logic [CW-1:0] phase_len(input seq_state_t s);
        unique case (s)
            ST_ROW:  return CW'(T_ROW - 1);
            ST_COL:  return CW'(T_COL - 1);
            ST_HOLD: return CW'(T_HOLD - 1);
            ST_PRE:  return CW'(T_PRE - 1);
            ST_RFSH: return CW'(T_RFSH - 1);
            default: return '0;
        endcase
    endfunction

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend)       nxt = ST_RFSH;
                else if (req_valid) nxt = ST_ROW;
            end
            ST_ROW:  if (cnt_zero) nxt = ST_COL;
            ST_COL:  if (cnt_zero) nxt = ST_HOLD;
            ST_HOLD: if (cnt_zero) nxt = ST_PRE;
            ST_RFSH: if (cnt_zero) nxt = ST_PRE;
            ST_PRE:  if (cnt_zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register, phase counter and host registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
            host_addr <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= phase_len(nxt);
            else if (!cnt_zero)
                cnt <= cnt - 1'b1;
            if (accept) begin
                wr_q      <= req_write;
                wdata_q   <= req_wdata;
                host_addr <= req_addr;
            end
            rsp_done <= col_end;
            if (col_end && !wr_q)
                rsp_rdata <= dq_in;
        end
    end

    // strobe and pin-select decode
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        oe_n     = 1'b1;
        dq_oe    = 1'b0;
        addr_sel = ASEL_ROW;
        unique case (state)
            ST_ROW: begin
                ras_n = 1'b0;
            end
            ST_COL: begin
                ras_n    = 1'b0;
                cas_n    = 1'b0;
                addr_sel = ASEL_COL;
                if (wr_q) begin
                    we_n  = 1'b0;
                    dq_oe = 1'b1;
                end else begin
                    oe_n  = 1'b0;
                end
            end
            ST_HOLD: begin
                ras_n    = 1'b0;
                addr_sel = ASEL_COL;
                dq_oe    = wr_q;
            end
            ST_RFSH: begin
                ras_n    = 1'b0;
                addr_sel = ASEL_REF;
            end
            default: ;
        endcase
    end

    p_we_oe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_accept_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!ras_n && cas_n));

    p_refresh_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pend && req_valid) |=> (state == ST_RFSH));

    p_rise_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n && we_n && oe_n));

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS      = 8,
    parameter int DATA_W        = 4,
    parameter int RETAIN_CYCLES = 800000,
    parameter int T_ROW         = 2,
    parameter int T_COL         = 2,
    parameter int T_HOLD        = 1,
    parameter int T_PRE         = 2,
    parameter int T_RFSH        = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [2*ROW_BITS-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ROW_BITS-1:0]   dram_addr,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic                  dram_oe_n,
    output logic [DATA_W-1:0]     dram_dq_out,
    output logic                  dram_dq_oe,
    input  logic [DATA_W-1:0]     dram_dq_in
);
    localparam int AW = 2 * ROW_BITS;

    logic                ref_pend;
    logic                ref_grant;
    logic                ref_finish;
    logic [ROW_BITS-1:0] ref_row;
    addr_sel_t           addr_sel;
    logic [AW-1:0]       host_addr;

    dram_refresh_sched #(
        .RETAIN_CYCLES(RETAIN_CYCLES),
        .ROW_BITS     (ROW_BITS)
    ) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (ref_grant),
        .finish(ref_finish),
        .pend  (ref_pend),
        .row   (ref_row)
    );

    dram_seq_fsm #(
        .ROW_BITS(ROW_BITS),
        .DATA_W  (DATA_W),
        .T_ROW   (T_ROW),
        .T_COL   (T_COL),
        .T_HOLD  (T_HOLD),
        .T_PRE   (T_PRE),
        .T_RFSH  (T_RFSH)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .ref_pend  (ref_pend),
        .ref_grant (ref_grant),
        .ref_finish(ref_finish),
        .addr_sel  (addr_sel),
        .host_addr (host_addr),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .dq_out    (dram_dq_out),
        .dq_oe     (dram_dq_oe),
        .dq_in     (dram_dq_in)
    );

    dram_addr_mux #(
        .ROW_BITS(ROW_BITS)
    ) u_amux (
        .sel      (addr_sel),
        .host_addr(host_addr),
        .ref_row  (ref_row),
        .pin_addr (dram_addr)
    );

    // R3: column half on the pins when the column strobe falls
    p_col_on_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (dram_addr == host_addr[AW-1:ROW_BITS]));

    // R10: refresh drives the counter row with the column strobe idle
    p_refresh_ras_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_sel == ASEL_REF) |-> (dram_cas_n && dram_addr == ref_row));

endmodule

// File: tb/dram_mux_ctrl_test.sv
`timescale 1ns/1ps
module dram_mux_ctrl_test;

    localparam int RETAIN   = 16384;
    localparam int INTERVAL = RETAIN / 256;
    localparam int SLACK    = 12;
    localparam int T_PRE    = 2;

    typedef struct {
        logic        wr;
        logic [15:0] a;
        logic [3:0]  d;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rsp_done;
    logic [3:0]  rsp_rdata;
    logic [7:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [3:0]  dram_dq_out;
    logic        dram_dq_oe;
    logic [3:0]  dram_dq_in = '0;

    always #2.5 clk = ~clk;

    dram_mux_ctrl #(.RETAIN_CYCLES(RETAIN), .T_PRE(T_PRE)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    item_t pin_q[$];
    item_t rsp_q[$];
    logic [3:0] smem   [256];
    logic [3:0] shadow [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fold(input logic [15:0] a);
        return {a[11:8], a[3:0]};
    endfunction

    // ---------------- memory model and pin monitor ----------------
    logic       prev_ras = 1'b1, prev_cas = 1'b1, prev_done = 1'b0;
    logic [7:0] row_l = '0, col_l = '0;
    bit         cas_seen = 0;
    bit         valid_at_fall = 0;
    int         cyc = 0, fall_cyc = 0, last_ref = 0, high_cnt = 1000;
    int         ref_count = 0, prio_hits = 0;
    logic [7:0] exp_ref_row = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_ras && !dram_ras_n) begin
                row_l = dram_addr;
                cas_seen = 0;
                valid_at_fall = req_valid;
                fall_cyc = cyc;
                chk(high_cnt >= T_PRE, "R8 precharge", high_cnt, T_PRE);
            end
            if (prev_cas && !dram_cas_n) begin
                item_t it;
                col_l = dram_addr;
                cas_seen = 1;
                chk(!dram_ras_n, "R3 cas inside ras", dram_ras_n, 0);
                if (pin_q.size() == 0) begin
                    chk(0, "R2 unexpected access", 1, 0);
                end else begin
                    it = pin_q.pop_front();
                    chk(row_l == it.a[7:0], "R2 row half", row_l, it.a[7:0]);
                    chk(col_l == it.a[15:8], "R3 column half", col_l, it.a[15:8]);
                    if (it.wr)
                        chk(!dram_we_n && dram_oe_n && dram_dq_oe && dram_dq_out == it.d,
                            "R4 write strobes/data", {dram_we_n, dram_oe_n, dram_dq_oe, dram_dq_out},
                            {3'b011, it.d});
                    else
                        chk(!dram_oe_n && dram_we_n && !dram_dq_oe,
                            "R5 read strobes", {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b100);
                end
            end
            if (!dram_we_n && !dram_oe_n)
                chk(0, "R6 we/oe both low", 0, 1);
            if (!dram_cas_n && !dram_we_n)
                smem[{col_l[3:0], row_l[3:0]}] = dram_dq_out;
            if (!dram_cas_n && !dram_oe_n)
                dram_dq_in = smem[{col_l[3:0], row_l[3:0]}];
            else
                dram_dq_in = 4'h0;
            if (!prev_ras && dram_ras_n && !cas_seen) begin
                chk(row_l == exp_ref_row, "R11 refresh row order", row_l, exp_ref_row);
                chk(fall_cyc - last_ref <= INTERVAL + SLACK, "R9 refresh gap",
                    fall_cyc - last_ref, INTERVAL + SLACK);
                chk(dram_we_n && dram_oe_n, "R10 refresh strobes", {dram_we_n, dram_oe_n}, 2'b11);
                if (valid_at_fall) prio_hits++;
                last_ref = fall_cyc;
                exp_ref_row = exp_ref_row + 8'd1;
                ref_count++;
            end
            high_cnt = dram_ras_n ? high_cnt + 1 : 0;
            // response scoreboard
            if (rsp_done) begin
                item_t r;
                chk(!prev_done, "R7 done width", prev_done, 0);
                chk(!prev_cas && dram_cas_n, "R7 done timing", {prev_cas, dram_cas_n}, 2'b01);
                if (rsp_q.size() == 0) begin
                    chk(0, "R7 spurious done", 1, 0);
                end else begin
                    r = rsp_q.pop_front();
                    if (!r.wr)
                        chk(rsp_rdata == r.d, "R5 read data", rsp_rdata, r.d);
                end
            end
            prev_ras  = dram_ras_n;
            prev_cas  = dram_cas_n;
            prev_done = rsp_done;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [15:0] a, input logic [3:0] d);
        item_t it;
        it.wr = wr;
        it.a  = a;
        it.d  = wr ? d : shadow[fold(a)];
        if (wr) shadow[fold(a)] = d;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        pin_q.push_back(it);
        rsp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R1 ready drops after accept", req_ready, 0);
    endtask

    task automatic drain();
        while (rsp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i]   = 4'h0;
            shadow[i] = 4'h0;
        end
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R13 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!rsp_done, "R13 done in reset", rsp_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && dram_ras_n && dram_cas_n, "R13 after reset",
            {req_ready, dram_ras_n, dram_cas_n}, 3'b111);

        // directed writes then reads (R1..R7)
        issue(1, 16'h12A5, 4'h9);
        issue(1, 16'hFF00, 4'h3);
        issue(1, 16'h00FF, 4'hC);
        issue(1, 16'h5A3C, 4'h6);
        issue(0, 16'h12A5, 4'h0);
        issue(0, 16'h00FF, 4'h0);
        issue(0, 16'hA5C3, 4'h0);      // never written: reads 0
        issue(0, 16'hFF00, 4'h0);
        issue(1, 16'h12A5, 4'hE);      // overwrite
        issue(0, 16'h12A5, 4'h0);
        issue(0, 16'h5A3C, 4'h0);
        drain();

        // back-to-back stream: refresh must cut in ahead of waiting requests (R12, R9)
        for (int i = 0; i < 200; i++)
            issue(1, 16'(i * 16'h0713 + 16'h0101), 4'(i));
        for (int i = 0; i < 200; i++)
            issue(0, 16'(i * 16'h0713 + 16'h0101), 4'h0);
        drain();

        // idle long enough for the row counter to wrap (R9, R10, R11)
        repeat (17000) @(negedge clk);
        chk(ref_count >= 257, "R11 wrap reached", ref_count, 257);
        chk(prio_hits > 0, "R12 refresh ahead of waiting request", prio_hits, 1);
        chk(pin_q.size() == 0 && rsp_q.size() == 0, "R7 all accesses answered",
            pin_q.size() + rsp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R7 actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule